// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block is the register side of a 32-pin general-purpose I/O port. Software reaches it over a plain memory-mapped bus: a word address, a write strobe, write data and combinational read data. For every pin the bank keeps an output level, a direction, a pull-disable bit, two function-select bits and a sleep-keep bit. From these it drives the per-pin pad controls: drive enable, drive value, pull enable, pull direction and a two-bit function code.

The output level and the direction are each reached through a pair of registers, one that sets bits and one that clears them. A write therefore touches only the pins whose bits are 1, and software never needs a read-modify-write. No separate register selects the pull direction. While a pin is an input, its output-level bit chooses pull-up (1) or pull-down (0). When `sleep_req` is high, every pin whose sleep-keep bit is 0 becomes an input with its configured pull. Such a pin returns to its programmed state when `sleep_req` falls. Pin levels pass through a two-flop synchronizer and a sampling register before software can read them.

Top module: `gpio_bank`

Register map (word addresses): 0 sampled input (read only), 1 level-set, 2 level-clear, 3 direction-set, 4 direction-clear, 5 pull-disable, 6 function-select A, 7 function-select B, 8 sleep-keep. Addresses 9 to 15 are unmapped.

## Requirements
- R1: While `rst` is high and after it falls, every pin is an input with level 0, pull enabled, pull-down and function code 0. Every register reads 0.
- R2: A write to address 1 sets the level bit of each pin whose write-data bit is 1 and leaves every other pin unchanged. Addresses 1 and 2 both read back the current level bits.
- R3: A write to address 2 clears the level bit of each pin whose write-data bit is 1 and leaves every other pin unchanged.
- R4: Writes to address 3 and address 4 set and clear direction bits in the same way, and both addresses read back the direction. Outside sleep, `pad_oe[i]` equals the direction bit (1 = output). `pad_out[i]` always equals the level bit.
- R5: Address 5 is an ordinary read/write register. Outside sleep, `pad_pull_en[i]` is 1 only when pin i is an input and its pull-disable bit is 0.
- R6: `pad_pull_up[i]` equals pin i's level bit. So on an input pin, writing address 1 selects pull-up and writing address 2 selects pull-down.
- R7: Addresses 6 (A) and 7 (B) are read/write. Pin i's code at `pad_fsel[2i+1:2i]` is {B bit, A bit}: 00 plain GPIO, 01 function A, 10 function B, 11 function C.
- R8: While `sleep_req` is 1, every pin whose sleep-keep bit (address 8) is 0 has `pad_oe`=0 and `pad_pull_en` = NOT pull-disable. Pins whose keep bit is 1 are unaffected. The function code and all register contents are unchanged, and the override is lifted as soon as `sleep_req` is 0.
- R9: Address 0 returns `pin_in` as sampled three clock edges earlier. A change is not visible after only two edges.
- R10: Writes to address 0 or to addresses 9 to 15 change no register and no pad output. Reads of addresses 9 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sleep_req | input | 1 | Sleep override request |
| pin_in | input | 32 | Asynchronous pin levels |
| pad_oe | output | 32 | Per-pin drive enable |
| pad_out | output | 32 | Per-pin drive value |
| pad_pull_en | output | 32 | Per-pin pull enable |
| pad_pull_up | output | 32 | Per-pin pull direction, 1 = up |
| pad_fsel | output | 64 | Two-bit function code per pin |

## Verification
The assertions take it for granted that no write carries the same bit in both the level-set and level-clear data, or in both direction-set and direction-clear, within one cycle. That case has no defined result. The stimulus writes one register per cycle, so the two halves of a pair are never written together, and the case never occurs. The synchronizer latency property also assumes that `pin_in` is a settled digital level at each sampling edge. The stimulus changes pins only at falling clock edges.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PINS_DEF = 32;
    localparam int ADDR_W   = 4;
    localparam int SYNC_DEF = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_DIN     = 4'd0,
        ADR_DSET    = 4'd1,
        ADR_DCLR    = 4'd2,
        ADR_DIRSET  = 4'd3,
        ADR_DIRCLR  = 4'd4,
        ADR_PULLOFF = 4'd5,
        ADR_FSA     = 4'd6,
        ADR_FSB     = 4'd7,
        ADR_KEEP    = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        FN_GPIO = 2'b00,
        FN_A    = 2'b01,
        FN_B    = 2'b10,
        FN_C    = 2'b11
    } pin_func_e;

    // Stored configuration of one pin.
    typedef struct packed {
        logic keep;
        logic sel_b;
        logic sel_a;
        logic pull_off;
        logic dir;
        logic dout;
    } pin_cfg_t;

    // Pad-facing controls of one pin.
    typedef struct packed {
        logic      oe;
        logic      val;
        logic      pe;
        logic      pu;
        pin_func_e fn;
    } pad_ctl_t;

    function automatic pin_func_e decode_func(input logic sel_a, input logic sel_b);
        unique case ({sel_b, sel_a})
            2'b00:   return FN_GPIO;
            2'b01:   return FN_A;
            2'b10:   return FN_B;
            default: return FN_C;
        endcase
    endfunction

    function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
        return a <= ADR_KEEP;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH  = PINS_DEF,
    parameter int STAGES = SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] din
);
    localparam int LAT = STAGES + 1;

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[s] <= '0;
                end else if (s == 0) begin
                    stg[s] <= pin_in;
                end else begin
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) din <= '0;
        else     din <= stg[STAGES-1];
    end

    // Warm-up counter so the latency check never looks across reset.
    logic [2:0] warm;
    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 3'd7) warm <= warm + 3'd1;
    end

    generate
        if (LAT == 3) begin : g_lat_chk
            p_sync_latency_r9: assert property (@(posedge clk) disable iff (rst)
                (warm >= 3'd3) |-> (din == $past(pin_in, 3)));
        end
    endgenerate

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = PINS_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   we,
    input  logic [NPINS-1:0]       wdata,
    input  logic [NPINS-1:0]       din,
    output logic [NPINS-1:0]       rdata,
    output pin_cfg_t [NPINS-1:0]   cfg
);

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            always_ff @(posedge clk) begin
                if (rst) begin
                    cfg[i] <= '0;
                end else if (we) begin
                    case (addr)
                        ADR_DSET:    if (wdata[i]) cfg[i].dout <= 1'b1;
                        ADR_DCLR:    if (wdata[i]) cfg[i].dout <= 1'b0;
                        ADR_DIRSET:  if (wdata[i]) cfg[i].dir  <= 1'b1;
                        ADR_DIRCLR:  if (wdata[i]) cfg[i].dir  <= 1'b0;
                        ADR_PULLOFF: cfg[i].pull_off <= wdata[i];
                        ADR_FSA:     cfg[i].sel_a    <= wdata[i];
                        ADR_FSB:     cfg[i].sel_b    <= wdata[i];
                        ADR_KEEP:    cfg[i].keep     <= wdata[i];
                        default:     ;
                    endcase
                end
            end

            p_set_level_r2: assert property (@(posedge clk) disable iff (rst)
                (we && addr == ADR_DSET && wdata[i]) |=> cfg[i].dout);
            p_clr_level_r3: assert property (@(posedge clk) disable iff (rst)
                (we && addr == ADR_DCLR && wdata[i]) |=> !cfg[i].dout);
            p_zero_bit_keeps_r2: assert property (@(posedge clk) disable iff (rst)
                (we && (addr == ADR_DSET || addr == ADR_DCLR) && !wdata[i])
                |=> $stable(cfg[i].dout));
            p_dir_set_r4: assert property (@(posedge clk) disable iff (rst)
                (we && addr == ADR_DIRSET && wdata[i]) |=> cfg[i].dir);
            p_dir_clr_r4: assert property (@(posedge clk) disable iff (rst)
                (we && addr == ADR_DIRCLR && wdata[i]) |=> !cfg[i].dir);
            p_unmapped_quiet_r10: assert property (@(posedge clk) disable iff (rst)
                (we && (!addr_mapped(addr) || addr == ADR_DIN)) |=> $stable(cfg[i]));
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NPINS; k++) begin
            case (addr)
                ADR_DIN:               rdata[k] = din[k];
                ADR_DSET, ADR_DCLR:    rdata[k] = cfg[k].dout;
                ADR_DIRSET, ADR_DIRCLR: rdata[k] = cfg[k].dir;
                ADR_PULLOFF:           rdata[k] = cfg[k].pull_off;
                ADR_FSA:               rdata[k] = cfg[k].sel_a;
                ADR_FSB:               rdata[k] = cfg[k].sel_b;
                ADR_KEEP:              rdata[k] = cfg[k].keep;
                default:               rdata[k] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg,
    input  logic     sleep_req,
    output pad_ctl_t pad
);
    logic forced;

    always_comb begin
        forced  = sleep_req && !cfg.keep;
        pad.oe  = cfg.dir && !forced;
        pad.val = cfg.dout;
        pad.pe  = !cfg.pull_off && (!cfg.dir || forced);
        pad.pu  = cfg.dout;
        pad.fn  = decode_func(cfg.sel_a, cfg.sel_b);
    end

    p_drive_no_pull_r5: assert property (@(posedge clk) disable iff (rst)
        pad.oe |-> !pad.pe);
    p_sleep_floats_r8: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && !cfg.keep) |-> !pad.oe);
    p_sleep_release_r8: assert property (@(posedge clk) disable iff (rst)
        (!sleep_req && cfg.dir) |-> pad.oe);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = PINS_DEF,
    parameter int STAGES = SYNC_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [NPINS-1:0]     bus_wdata,
    output logic [NPINS-1:0]     bus_rdata,
    input  logic                 sleep_req,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pad_oe,
    output logic [NPINS-1:0]     pad_out,
    output logic [NPINS-1:0]     pad_pull_en,
    output logic [NPINS-1:0]     pad_pull_up,
    output logic [2*NPINS-1:0]   pad_fsel
);
    localparam int FSEL_W = 2 * NPINS;

    logic [NPINS-1:0]     din;
    pin_cfg_t [NPINS-1:0] cfg;
    pad_ctl_t             pad [NPINS];

    gpio_in_sync #(.WIDTH(NPINS), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .din    (din)
    );

    gpio_reg_file #(.NPINS(NPINS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .din   (din),
        .rdata (bus_rdata),
        .cfg   (cfg)
    );

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pad
            gpio_pad_ctrl u_pad (
                .clk       (clk),
                .rst       (rst),
                .cfg       (cfg[i]),
                .sleep_req (sleep_req),
                .pad       (pad[i])
            );
            assign pad_oe[i]          = pad[i].oe;
            assign pad_out[i]         = pad[i].val;
            assign pad_pull_en[i]     = pad[i].pe;
            assign pad_pull_up[i]     = pad[i].pu;
            assign pad_fsel[2*i +: 2] = pad[i].fn;
        end
    endgenerate

    p_fsel_hold_in_sleep_r8: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && !bus_we) |=> $stable(pad_fsel[FSEL_W-1:0]));

endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/100ps
module gpio_bank_tb;
    import gpio_bank_pkg::*;

    localparam int N = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_we;
    logic [N-1:0]      bus_wdata;
    logic [N-1:0]      bus_rdata;
    logic              sleep_req;
    logic [N-1:0]      pin_in;
    logic [N-1:0]      pad_oe, pad_out, pad_pull_en, pad_pull_up;
    logic [2*N-1:0]    pad_fsel;

    int checks   = 0;
    int failures = 0;

    // Bench-side model of the programmed state.
    logic [N-1:0] m_dout, m_dir, m_poff, m_fa, m_fb, m_keep, m_pin;

    always #4 clk = ~clk;

    gpio_bank u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
        .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up), .pad_fsel(pad_fsel)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    function automatic logic [N-1:0] lfsr(input logic [N-1:0] x);
        return {x[N-2:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    task automatic check_all(input string req);
        logic [N-1:0] r;
        logic [N-1:0] forced, e_oe, e_pe;
        logic [2*N-1:0] e_fs;
        rd(4'd0, r); chk(req, "din",     r, m_pin);
        rd(4'd1, r); chk(req, "lvl@1",   r, m_dout);
        rd(4'd2, r); chk(req, "lvl@2",   r, m_dout);
        rd(4'd3, r); chk(req, "dir@3",   r, m_dir);
        rd(4'd4, r); chk(req, "dir@4",   r, m_dir);
        rd(4'd5, r); chk(req, "pulloff", r, m_poff);
        rd(4'd6, r); chk(req, "fselA",   r, m_fa);
        rd(4'd7, r); chk(req, "fselB",   r, m_fb);
        rd(4'd8, r); chk(req, "keep",    r, m_keep);
        forced = sleep_req ? ~m_keep : '0;
        e_oe   = m_dir & ~forced;
        e_pe   = ~m_poff & (~m_dir | forced);
        for (int i = 0; i < N; i++) e_fs[2*i +: 2] = {m_fb[i], m_fa[i]};
        chk(req, "pad_oe",      pad_oe,      e_oe);
        chk(req, "pad_out",     pad_out,     m_dout);
        chk(req, "pad_pull_en", pad_pull_en, e_pe);
        chk(req, "pad_pull_up", pad_pull_up, m_dout);
        chk(req, "pad_fsel",    pad_fsel,    e_fs);
    endtask

    initial begin
        #(8ns * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] p, q, r;
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        sleep_req = 1'b0; pin_in = '0;
        {m_dout, m_dir, m_poff, m_fa, m_fb, m_keep, m_pin} = '0;
        repeat (3) @(negedge clk);
        // R1: pads during reset
        chk("R1", "oe in reset", pad_oe, '0);
        chk("R1", "pe in reset", pad_pull_en, {N{1'b1}});
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R2 / R3: walking single bits through set and clear
        for (int i = 0; i < N; i++) begin
            wr(4'd1, N'(1) << i); m_dout[i] = 1'b1;
            rd(4'd1, r); chk("R2", "walk set", r, m_dout);
        end
        for (int i = 0; i < N; i += 2) begin
            wr(4'd2, N'(1) << i); m_dout[i] = 1'b0;
            rd(4'd2, r); chk("R3", "walk clr", r, m_dout);
        end
        p = 32'h1234_5678;
        for (int k = 0; k < 12; k++) begin
            p = lfsr(p); q = lfsr(p);
            wr(4'd1, p); m_dout = m_dout | p;
            wr(4'd2, q); m_dout = m_dout & ~q;
            check_all("R2 R3");
        end

        // R4: direction set/clear with pad drive
        for (int k = 0; k < 10; k++) begin
            p = lfsr(p); q = lfsr(p);
            wr(4'd3, p); m_dir = m_dir | p;
            check_all("R4");
            wr(4'd4, q); m_dir = m_dir & ~q;
            check_all("R4");
        end

        // R5 / R6: pull-disable sweep and pull direction from level bit
        for (int k = 0; k < 10; k++) begin
            p = lfsr(p); wr(4'd5, p); m_poff = p;
            p = lfsr(p); wr(4'd1, p); m_dout = m_dout | p;
            check_all("R5 R6");
            p = lfsr(p); wr(4'd2, p); m_dout = m_dout & ~p;
            check_all("R5 R6");
        end

        // R7: every function code on every pin
        for (int c = 0; c < 4; c++) begin
            wr(4'd6, c[0] ? '1 : '0); m_fa = c[0] ? '1 : '0;
            wr(4'd7, c[1] ? '1 : '0); m_fb = c[1] ? '1 : '0;
            check_all("R7");
        end
        wr(4'd6, 32'hAAAA_AAAA); m_fa = 32'hAAAA_AAAA;
        wr(4'd7, 32'hCCCC_CCCC); m_fb = 32'hCCCC_CCCC;
        check_all("R7");

        // R8: sleep override, keep pattern sweep, writes during sleep
        wr(4'd3, 32'hFFFF_0000); m_dir = m_dir | 32'hFFFF_0000;
        for (int k = 0; k < 6; k++) begin
            p = lfsr(p); wr(4'd8, p); m_keep = p;
            sleep_req = 1'b1; #0.2;
            check_all("R8");
            p = lfsr(p); wr(4'd1, p); m_dout = m_dout | p;
            check_all("R8");
            sleep_req = 1'b0; #0.2;
            check_all("R8");
        end

        // R9: synchronizer latency
        for (int k = 0; k < 6; k++) begin
            p = lfsr(p);
            pin_in = p;
            @(negedge clk); @(negedge clk);
            rd(4'd0, r); chk("R9", "din after 2 edges", r, m_pin);
            @(negedge clk);
            m_pin = p;
            rd(4'd0, r); chk("R9", "din after 3 edges", r, m_pin);
        end

        // R10: writes to read-only and unmapped addresses
        for (int a = 9; a < 16; a++) begin
            wr(4'(a), '1);
            rd(4'(a), r); chk("R10", "unmapped read", r, '0);
        end
        wr(4'd0, ~m_pin);
        check_all("R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule